// File: doc/BRIEF.md
# Bus-Reset-Synchronised CSR Shadow Unit

This block keeps the registers that describe a serial-bus node's configuration image and its bus-resource counters, and it makes every change to them line up with a bus reset. Software never moves the live configuration-image pointer directly. It writes a staging copy, and that copy only takes over when the next bus reset arrives. At that moment the unit also fetches the new image's header word and bus-options word from memory, so the node never presents a half-updated image.

On every bus reset the unit also restores the bandwidth counter and the two channel-availability masks from three initial-value registers that software can program. While a bus-reset event is still pending, the control register and the four request-filter registers ignore writes, so software cannot act on values that were chosen before the reset.

The host sees a plain register port: a write strobe, a read strobe, a byte address and 32-bit data. Read data appears one cycle after the read strobe. A single-cycle-latency memory port serves the image fetch.

Top module: `csr_shadow_top`

## Requirements
- R1: After reset, the status word (offset 0x00) reads 0, the live map address (0x0C) and all protected registers read 0, bandwidth (0x24) and initial bandwidth (0xB0) read 0x1333, and channels-high/low (0x28, 0x2C) and their initial copies (0xB4, 0xB8) read 0xFFFF_FFFF.
- R2: A write to the map address (0x0C) does not change the value read back from 0x0C or the `rom_base` output until a bus reset commits it.
- R3: A map-address write arms an update (status bit 1) only when `link_enable` and `image_valid` are both high. Without an armed update, a bus reset leaves the map address, header (0x04) and options (0x08) unchanged.
- R4: A bus reset with an armed update makes the last written map address live on 0x0C and `rom_base`, clears the arm bit, and holds `fetch_busy` (also status bit 2) high for exactly 3 cycles. During that time it reads memory at the new base into the header and at base+8 into the options.
- R5: Every map-address write arms the update, including one that repeats the live value, and the last write before the bus reset is the one that takes effect.
- R6: Every bus reset copies 0xB0, 0xB4 and 0xB8 into bandwidth, channels-high and channels-low, replacing any value software wrote there.
- R7: The initial-value registers and the live resource registers can be written by the host. The bandwidth registers keep only bits 12:0.
- R8: A bus reset sets the event flag (status bit 0). Writing 1 to bit 0 of 0x00 clears it, and writing 0 there leaves it set.
- R9: The control register (0x10) and the filter registers (0x14, 0x18, 0x1C, 0x20) ignore writes while the event flag is set and accept them when it is clear.
- R10: `host_rdata` updates only on the cycle after `host_rd` and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe |
| host_addr | input | 8 | Register byte address |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, valid the cycle after host_rd |
| bus_reset | input | 1 | One-cycle bus-reset event |
| link_enable | input | 1 | Link enabled flag |
| image_valid | input | 1 | New configuration image ready flag |
| mem_rd_en | output | 1 | Image memory read request |
| mem_addr | output | 32 | Image memory byte address |
| mem_rdata | input | 32 | Image memory data, one cycle after request |
| rom_base | output | 32 | Live configuration-image base address |
| fetch_busy | output | 1 | Header/options fetch in progress |

## Verification
The bench reads the map address right after a staging write to catch a design that exposes the staging copy early. It writes the map twice before a reset to catch one that commits the first value or compares against the live one. It writes with one of the two enable flags low to catch arming that ignores a flag. It programs non-default initial values, including an oversized bandwidth, and overwrites the live counters to catch a reload that uses hard-coded defaults or forgets one register. It then writes the protected registers both with the event flag set and after a write-one-to-clear, which catches a gate that is missing, inverted or stuck. Fetch timing is checked cycle by cycle against a memory model, so a wrong options offset or a wrong busy length shows up as a header, options or busy mismatch.

// File: rtl/csr_shadow_pkg.sv
package csr_shadow_pkg;

    localparam int DW = 32;
    localparam int HOST_AW = 8;
    localparam int PROT_N = 5;

    typedef enum logic [3:0] {
        RID_STATUS, RID_HDR, RID_OPT, RID_MAP,
        RID_CTRL, RID_AF_HI, RID_AF_LO, RID_PF_HI, RID_PF_LO,
        RID_BW, RID_CH_HI, RID_CH_LO,
        RID_INI_BW, RID_INI_HI, RID_INI_LO, RID_NONE
    } reg_id_e;

    typedef enum logic [1:0] {
        F_IDLE, F_HDR, F_OPT, F_FIN
    } fetch_st_e;

    typedef struct packed {
        logic bw;
        logic ch_hi;
        logic ch_lo;
        logic ini_bw;
        logic ini_hi;
        logic ini_lo;
    } irm_wr_t;

    function automatic reg_id_e decode_addr(input logic [HOST_AW-1:0] a);
        reg_id_e id;
        if (a[1:0] != 2'b00) begin
            id = RID_NONE;
        end else begin
            case (a[HOST_AW-1:2])
                6'h00:   id = RID_STATUS;
                6'h01:   id = RID_HDR;
                6'h02:   id = RID_OPT;
                6'h03:   id = RID_MAP;
                6'h04:   id = RID_CTRL;
                6'h05:   id = RID_AF_HI;
                6'h06:   id = RID_AF_LO;
                6'h07:   id = RID_PF_HI;
                6'h08:   id = RID_PF_LO;
                6'h09:   id = RID_BW;
                6'h0A:   id = RID_CH_HI;
                6'h0B:   id = RID_CH_LO;
                6'h2C:   id = RID_INI_BW;
                6'h2D:   id = RID_INI_HI;
                6'h2E:   id = RID_INI_LO;
                default: id = RID_NONE;
            endcase
        end
        return id;
    endfunction

    function automatic logic is_protected(input reg_id_e id);
        return (id == RID_CTRL) || (id == RID_AF_HI) || (id == RID_AF_LO) ||
               (id == RID_PF_HI) || (id == RID_PF_LO);
    endfunction

    function automatic logic [2:0] prot_slot(input reg_id_e id);
        logic [2:0] s;
        case (id)
            RID_AF_HI: s = 3'd1;
            RID_AF_LO: s = 3'd2;
            RID_PF_HI: s = 3'd3;
            RID_PF_LO: s = 3'd4;
            default:   s = 3'd0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/csr_prot_bank.sv
module csr_prot_bank
    import csr_shadow_pkg::*;
#(
    parameter int N = PROT_N,
    parameter int W = DW,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                lock,
    input  logic                wr_en,
    input  logic [IW-1:0]       wr_idx,
    input  logic [W-1:0]        wr_data,
    output logic [N-1:0][W-1:0] regs
);

    for (genvar i = 0; i < N; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[i] <= '0;
            end else if (wr_en && !lock && (wr_idx == IW'(i))) begin
                regs[i] <= wr_data;
            end
        end

        a_r9_locked_slot: assert property (@(posedge clk) disable iff (rst)
            (lock && wr_en && wr_idx == IW'(i)) |=> $stable(regs[i]));
        a_r9_open_slot: assert property (@(posedge clk) disable iff (rst)
            (!lock && wr_en && wr_idx == IW'(i)) |=> (regs[i] == $past(wr_data)));
    end

endmodule

// File: rtl/csr_irm_reload.sv
module csr_irm_reload
    import csr_shadow_pkg::*;
#(
    parameter int BW_W = 13,
    parameter logic [BW_W-1:0] BW_RST = 13'h1333,
    parameter logic [DW-1:0] CH_RST = 32'hFFFF_FFFF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bus_reset,
    input  irm_wr_t         wr_sel,
    input  logic [DW-1:0]   wr_data,
    output logic [BW_W-1:0] bw_live,
    output logic [DW-1:0]   ch_hi,
    output logic [DW-1:0]   ch_lo,
    output logic [BW_W-1:0] ini_bw,
    output logic [DW-1:0]   ini_hi,
    output logic [DW-1:0]   ini_lo
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ini_bw <= BW_RST;
            ini_hi <= CH_RST;
            ini_lo <= CH_RST;
        end else begin
            if (wr_sel.ini_bw) ini_bw <= wr_data[BW_W-1:0];
            if (wr_sel.ini_hi) ini_hi <= wr_data;
            if (wr_sel.ini_lo) ini_lo <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bw_live <= BW_RST;
            ch_hi   <= CH_RST;
            ch_lo   <= CH_RST;
        end else if (bus_reset) begin
            bw_live <= ini_bw;
            ch_hi   <= ini_hi;
            ch_lo   <= ini_lo;
        end else begin
            if (wr_sel.bw)    bw_live <= wr_data[BW_W-1:0];
            if (wr_sel.ch_hi) ch_hi   <= wr_data;
            if (wr_sel.ch_lo) ch_lo   <= wr_data;
        end
    end

    a_r6_reload: assert property (@(posedge clk) disable iff (rst)
        bus_reset |=> (bw_live == $past(ini_bw) && ch_hi == $past(ini_hi) &&
                       ch_lo == $past(ini_lo)));

endmodule

// File: rtl/csr_rom_shadow.sv
module csr_rom_shadow
    import csr_shadow_pkg::*;
#(
    parameter int MEM_AW = 32,
    parameter int OPT_OFS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_reset,
    input  logic              link_en,
    input  logic              img_valid,
    input  logic              map_wr,
    input  logic              hdr_wr,
    input  logic              opt_wr,
    input  logic [DW-1:0]     wr_data,
    input  logic [DW-1:0]     mem_rdata,
    output logic              mem_rd_en,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [MEM_AW-1:0] active_map,
    output logic              armed,
    output logic              busy,
    output logic [DW-1:0]     rom_hdr,
    output logic [DW-1:0]     bus_opt
);

    logic [MEM_AW-1:0] shadow_map;
    fetch_st_e         st;
    logic              commit;

    assign commit = bus_reset && armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_map <= '0;
            active_map <= '0;
            armed      <= 1'b0;
            st         <= F_IDLE;
        end else begin
            if (map_wr) shadow_map <= wr_data[MEM_AW-1:0];
            if (map_wr && link_en && img_valid) begin
                armed <= 1'b1;
            end else if (commit) begin
                armed <= 1'b0;
            end
            if (commit) begin
                active_map <= shadow_map;
                st         <= F_HDR;
            end else begin
                case (st)
                    F_HDR:   st <= F_OPT;
                    F_OPT:   st <= F_FIN;
                    F_FIN:   st <= F_IDLE;
                    default: st <= F_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rom_hdr <= '0;
            bus_opt <= '0;
        end else begin
            if (st == F_OPT)   rom_hdr <= mem_rdata;
            else if (hdr_wr)   rom_hdr <= wr_data;
            if (st == F_FIN)   bus_opt <= mem_rdata;
            else if (opt_wr)   bus_opt <= wr_data;
        end
    end

    assign mem_rd_en = (st == F_HDR) || (st == F_OPT);
    assign mem_addr  = (st == F_OPT) ? active_map + MEM_AW'(OPT_OFS) : active_map;
    assign busy      = (st != F_IDLE);

    a_r2_live_holds: assert property (@(posedge clk) disable iff (rst)
        !bus_reset |=> $stable(active_map));
    a_r3_arm_gate: assert property (@(posedge clk) disable iff (rst)
        $rose(armed) |-> $past(map_wr && link_en && img_valid));
    a_r4_commit: assert property (@(posedge clk) disable iff (rst)
        (bus_reset && armed) |=> (busy && active_map == $past(shadow_map)));
    a_r4_arm_clear: assert property (@(posedge clk) disable iff (rst)
        (bus_reset && armed && !map_wr) |=> !armed);
    a_r4_fetch_reads: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (mem_rd_en && mem_addr == active_map));

endmodule

// File: rtl/csr_shadow_top.sv
module csr_shadow_top
    import csr_shadow_pkg::*;
#(
    parameter int MEM_AW = 32,
    parameter int OPT_OFS = 8,
    parameter int BW_W = 13,
    parameter logic [BW_W-1:0] BW_RST = 13'h1333,
    parameter logic [DW-1:0] CH_RST = 32'hFFFF_FFFF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               host_wr,
    input  logic               host_rd,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [DW-1:0]      host_wdata,
    output logic [DW-1:0]      host_rdata,
    input  logic               bus_reset,
    input  logic               link_enable,
    input  logic               image_valid,
    output logic               mem_rd_en,
    output logic [MEM_AW-1:0]  mem_addr,
    input  logic [DW-1:0]      mem_rdata,
    output logic [MEM_AW-1:0]  rom_base,
    output logic               fetch_busy
);

    localparam int PIW = $clog2(PROT_N);

    reg_id_e                   id;
    logic                      evt;
    logic                      armed;
    logic                      busy;
    logic [MEM_AW-1:0]         active_map;
    logic [DW-1:0]             rom_hdr;
    logic [DW-1:0]             bus_opt;
    logic [PROT_N-1:0][DW-1:0] prot_regs;
    logic [BW_W-1:0]           bw_live;
    logic [BW_W-1:0]           ini_bw;
    logic [DW-1:0]             ch_hi;
    logic [DW-1:0]             ch_lo;
    logic [DW-1:0]             ini_hi;
    logic [DW-1:0]             ini_lo;
    irm_wr_t                   irm_sel;
    logic                      prot_wr;
    logic [DW-1:0]             rd_val;

    assign id = decode_addr(host_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            evt <= 1'b0;
        end else if (bus_reset) begin
            evt <= 1'b1;
        end else if (host_wr && id == RID_STATUS && host_wdata[0]) begin
            evt <= 1'b0;
        end
    end

    assign prot_wr = host_wr && is_protected(id);

    always_comb begin
        irm_sel        = '0;
        irm_sel.bw     = host_wr && (id == RID_BW);
        irm_sel.ch_hi  = host_wr && (id == RID_CH_HI);
        irm_sel.ch_lo  = host_wr && (id == RID_CH_LO);
        irm_sel.ini_bw = host_wr && (id == RID_INI_BW);
        irm_sel.ini_hi = host_wr && (id == RID_INI_HI);
        irm_sel.ini_lo = host_wr && (id == RID_INI_LO);
    end

    csr_prot_bank #(.N(PROT_N), .W(DW)) u_prot (
        .clk     (clk),
        .rst     (rst),
        .lock    (evt),
        .wr_en   (prot_wr),
        .wr_idx  (PIW'(prot_slot(id))),
        .wr_data (host_wdata),
        .regs    (prot_regs)
    );

    csr_irm_reload #(.BW_W(BW_W), .BW_RST(BW_RST), .CH_RST(CH_RST)) u_irm (
        .clk       (clk),
        .rst       (rst),
        .bus_reset (bus_reset),
        .wr_sel    (irm_sel),
        .wr_data   (host_wdata),
        .bw_live   (bw_live),
        .ch_hi     (ch_hi),
        .ch_lo     (ch_lo),
        .ini_bw    (ini_bw),
        .ini_hi    (ini_hi),
        .ini_lo    (ini_lo)
    );

    csr_rom_shadow #(.MEM_AW(MEM_AW), .OPT_OFS(OPT_OFS)) u_rom (
        .clk        (clk),
        .rst        (rst),
        .bus_reset  (bus_reset),
        .link_en    (link_enable),
        .img_valid  (image_valid),
        .map_wr     (host_wr && id == RID_MAP),
        .hdr_wr     (host_wr && id == RID_HDR),
        .opt_wr     (host_wr && id == RID_OPT),
        .wr_data    (host_wdata),
        .mem_rdata  (mem_rdata),
        .mem_rd_en  (mem_rd_en),
        .mem_addr   (mem_addr),
        .active_map (active_map),
        .armed      (armed),
        .busy       (busy),
        .rom_hdr    (rom_hdr),
        .bus_opt    (bus_opt)
    );

    always_comb begin
        case (id)
            RID_STATUS: rd_val = {{(DW-3){1'b0}}, busy, armed, evt};
            RID_HDR:    rd_val = rom_hdr;
            RID_OPT:    rd_val = bus_opt;
            RID_MAP:    rd_val = DW'(active_map);
            RID_CTRL:   rd_val = prot_regs[0];
            RID_AF_HI:  rd_val = prot_regs[1];
            RID_AF_LO:  rd_val = prot_regs[2];
            RID_PF_HI:  rd_val = prot_regs[3];
            RID_PF_LO:  rd_val = prot_regs[4];
            RID_BW:     rd_val = DW'(bw_live);
            RID_CH_HI:  rd_val = ch_hi;
            RID_CH_LO:  rd_val = ch_lo;
            RID_INI_BW: rd_val = DW'(ini_bw);
            RID_INI_HI: rd_val = ini_hi;
            RID_INI_LO: rd_val = ini_lo;
            default:    rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            host_rdata <= '0;
        end else if (host_rd) begin
            host_rdata <= rd_val;
        end
    end

    assign rom_base   = active_map;
    assign fetch_busy = busy;

    a_r8_event_set: assert property (@(posedge clk) disable iff (rst)
        bus_reset |=> evt);
    a_r10_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        !host_rd |=> $stable(host_rdata));
    a_r4_busy_len: assert property (@(posedge clk) disable iff (rst)
        ($past(busy, 3) && $past(busy, 2) && $past(busy) && !$past(bus_reset)) |-> !busy);

endmodule

// File: tb/test_csr_shadow_top.sv
module test_csr_shadow_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [7:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        bus_reset = 1'b0;
    logic        link_enable = 1'b0;
    logic        image_valid = 1'b0;
    logic        mem_rd_en;
    logic [31:0] mem_addr;
    logic [31:0] mem_rdata = '0;
    logic [31:0] rom_base;
    logic        fetch_busy;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    csr_shadow_top i_csr_shadow_top (
        .clk         (clk),
        .rst         (rst),
        .host_wr     (host_wr),
        .host_rd     (host_rd),
        .host_addr   (host_addr),
        .host_wdata  (host_wdata),
        .host_rdata  (host_rdata),
        .bus_reset   (bus_reset),
        .link_enable (link_enable),
        .image_valid (image_valid),
        .mem_rd_en   (mem_rd_en),
        .mem_addr    (mem_addr),
        .mem_rdata   (mem_rdata),
        .rom_base    (rom_base),
        .fetch_busy  (fetch_busy)
    );

    function automatic logic [31:0] img_word(input logic [31:0] a);
        return (a ^ 32'hC3A5_0F96) + {a[15:0], a[31:16]};
    endfunction

    always_ff @(posedge clk) begin
        if (mem_rd_en) mem_rdata <= img_word(mem_addr);
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        @(negedge clk);
        host_rd = 1'b0;
        d = host_rdata;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic pulse_reset();
        @(negedge clk);
        bus_reset = 1'b1;
        @(negedge clk);
        bus_reset = 1'b0;
    endtask

    task automatic t_reset_state();
        rd_chk("R1 status", 8'h00, 32'h0);
        rd_chk("R1 map", 8'h0C, 32'h0);
        rd_chk("R1 ctrl", 8'h10, 32'h0);
        rd_chk("R1 filter", 8'h1C, 32'h0);
        rd_chk("R1 bw", 8'h24, 32'h1333);
        rd_chk("R1 ch_hi", 8'h28, 32'hFFFF_FFFF);
        rd_chk("R1 ch_lo", 8'h2C, 32'hFFFF_FFFF);
        rd_chk("R1 ini_bw", 8'hB0, 32'h1333);
        rd_chk("R1 ini_hi", 8'hB4, 32'hFFFF_FFFF);
        rd_chk("R1 ini_lo", 8'hB8, 32'hFFFF_FFFF);
        chk("R1 busy", {31'b0, fetch_busy}, 32'h0);
    endtask

    task automatic t_arm_gate();
        wr(8'h04, 32'h0000_0055);
        wr(8'h08, 32'h0000_0066);
        link_enable = 1'b0; image_valid = 1'b1;
        wr(8'h0C, 32'h0000_2000);
        rd_chk("R3 no arm link low", 8'h00, 32'h0);
        link_enable = 1'b1; image_valid = 1'b0;
        wr(8'h0C, 32'h0000_2400);
        rd_chk("R3 no arm image low", 8'h00, 32'h0);
        pulse_reset();
        repeat (4) @(negedge clk);
        rd_chk("R3 map kept", 8'h0C, 32'h0);
        rd_chk("R3 hdr kept", 8'h04, 32'h55);
        rd_chk("R3 opt kept", 8'h08, 32'h66);
        chk("R3 rom_base kept", rom_base, 32'h0);
        rd_chk("R8 event set", 8'h00, 32'h1);
        wr(8'h00, 32'h0);
        rd_chk("R8 zero write keeps", 8'h00, 32'h1);
        wr(8'h00, 32'h1);
        rd_chk("R8 w1c clears", 8'h00, 32'h0);
    endtask

    task automatic t_commit();
        link_enable = 1'b1; image_valid = 1'b1;
        wr(8'h0C, 32'h0000_3000);
        rd_chk("R2 map not live", 8'h0C, 32'h0);
        chk("R2 rom_base not live", rom_base, 32'h0);
        rd_chk("R3 armed", 8'h00, 32'h2);
        wr(8'h0C, 32'h0000_4000);
        @(negedge clk);
        bus_reset = 1'b1;
        @(negedge clk);
        bus_reset = 1'b0;
        chk("R4 busy c1", {31'b0, fetch_busy}, 32'h1);
        chk("R5 last write live", rom_base, 32'h0000_4000);
        @(negedge clk);
        chk("R4 busy c2", {31'b0, fetch_busy}, 32'h1);
        @(negedge clk);
        chk("R4 busy c3", {31'b0, fetch_busy}, 32'h1);
        @(negedge clk);
        chk("R4 busy ends", {31'b0, fetch_busy}, 32'h0);
        rd_chk("R4 map visible", 8'h0C, 32'h0000_4000);
        rd_chk("R4 header fetched", 8'h04, img_word(32'h0000_4000));
        rd_chk("R4 options fetched", 8'h08, img_word(32'h0000_4008));
        rd_chk("R4 arm cleared", 8'h00, 32'h1);
        wr(8'h00, 32'h1);
    endtask

    task automatic t_rearm_same();
        link_enable = 1'b1; image_valid = 1'b1;
        wr(8'h0C, 32'h0000_4000);
        rd_chk("R5 same value arms", 8'h00, 32'h2);
        pulse_reset();
        chk("R5 fetch again", {31'b0, fetch_busy}, 32'h1);
        repeat (4) @(negedge clk);
        rd_chk("R5 map same", 8'h0C, 32'h0000_4000);
        wr(8'h00, 32'h1);
    endtask

    task automatic t_reload();
        wr(8'hB0, 32'hFFFF_FFFF);
        rd_chk("R7 ini_bw masked", 8'hB0, 32'h0000_1FFF);
        wr(8'hB4, 32'h7FFF_FFFF);
        wr(8'hB8, 32'hFFFF_FFFE);
        rd_chk("R7 ini_hi", 8'hB4, 32'h7FFF_FFFF);
        wr(8'h24, 32'h0000_0005);
        wr(8'h28, 32'h0000_0000);
        wr(8'h2C, 32'h1234_5678);
        rd_chk("R7 bw write", 8'h24, 32'h5);
        rd_chk("R7 ch_lo write", 8'h2C, 32'h1234_5678);
        pulse_reset();
        rd_chk("R6 bw reload", 8'h24, 32'h0000_1FFF);
        rd_chk("R6 ch_hi reload", 8'h28, 32'h7FFF_FFFF);
        rd_chk("R6 ch_lo reload", 8'h2C, 32'hFFFF_FFFE);
    endtask

    task automatic t_protect();
        rd_chk("R8 event before lock", 8'h00, 32'h1);
        wr(8'h10, 32'h0000_1234);
        wr(8'h14, 32'hAAAA_0001);
        wr(8'h20, 32'hAAAA_0004);
        rd_chk("R9 ctrl locked", 8'h10, 32'h0);
        rd_chk("R9 af_hi locked", 8'h14, 32'h0);
        rd_chk("R9 pf_lo locked", 8'h20, 32'h0);
        wr(8'h00, 32'h1);
        wr(8'h10, 32'h0000_1234);
        wr(8'h14, 32'hBBBB_0001);
        wr(8'h18, 32'hBBBB_0002);
        wr(8'h1C, 32'hBBBB_0003);
        wr(8'h20, 32'hBBBB_0004);
        rd_chk("R9 ctrl open", 8'h10, 32'h0000_1234);
        rd_chk("R9 af_hi open", 8'h14, 32'hBBBB_0001);
        rd_chk("R9 af_lo open", 8'h18, 32'hBBBB_0002);
        rd_chk("R9 pf_hi open", 8'h1C, 32'hBBBB_0003);
        rd_chk("R9 pf_lo open", 8'h20, 32'hBBBB_0004);
        pulse_reset();
        wr(8'h18, 32'h0);
        rd_chk("R9 relocked", 8'h18, 32'hBBBB_0002);
    endtask

    task automatic t_read_hold();
        logic [31:0] v;
        rd(8'h24, v);
        wr(8'h24, 32'h0000_0777);
        @(negedge clk);
        chk("R10 rdata holds", host_rdata, v);
        rd_chk("R10 new read", 8'h24, 32'h0000_0777);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset_state();
        t_arm_gate();
        t_commit();
        t_rearm_same();
        t_reload();
        t_protect();
        t_read_hold();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule